// File: doc/BRIEF.md
# Watchdog Timer with Delayed System Reset

This block watches for a stalled program. A counter advances on every clock while the run bit is set. Software must restart it before it reaches the selected interval. If it reaches the interval first, a sticky timeout flag is set. The flag drives the interrupt output when interrupts are enabled.

When the reset enable is set at the moment of the timeout, a grace window of a fixed number of clocks opens. If software restarts the watchdog inside that window, the reset is cancelled. Otherwise a system reset pulse of fixed length is driven when the window closes. Software reaches everything through one 7-bit control register, which has a write strobe and a combinational read-back.

Control register bits:
- bit 0: run
- bit 1: interrupt enable
- bit 2: reset enable
- bits 4:3: interval select
- bit 5: timeout flag
- bit 6: restart

Top module: `watchdog_ctl`

## Requirements
- R1: During and after reset, the read-back is 0, `irq` is 0 and `sys_rst` is 0.
- R2: The counter advances only while bit 0 (run) is 1, and holds its value while run is 0. The timeout flag (bit 5) reads 1 exactly 2^(TMO_BASE+TMO_STEP*sel) running clocks after a restart, where sel is bits 4:3.
- R3: A write with bit 6 set returns the counter to zero, so the full interval starts again. A write with bit 6 clear does not touch the count. Bit 6 always reads 0.
- R4: The timeout flag stays set until a write has bit 5 set, or until a restart. A write with bit 5 clear leaves the flag unchanged.
- R5: `irq` equals the timeout flag ANDed with bit 1 (interrupt enable).
- R6: If bit 2 (reset enable) is set at the timeout, `sys_rst` rises exactly GRACE_CLKS clocks after the timeout and stays high for exactly PULSE_CLKS clocks.
- R7: A restart written while the grace window is open cancels the pending reset and clears the timeout flag.
- R8: A timeout with bit 2 clear sets the flag but never asserts `sys_rst`.
- R9: Timeouts that occur while a grace window or a reset pulse is in progress neither lengthen the window nor shift the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 7 | Control register write value |
| rd_data | output | 7 | Control register read-back |
| irq | output | 1 | Timeout interrupt (level) |
| sys_rst | output | 1 | System reset pulse |

## Verification
The bench builds the block with TMO_BASE=3, TMO_STEP=1, GRACE_CLKS=16 and PULSE_CLKS=4. The four intervals then shrink to 8, 16, 32 and 64 clocks, so every interval select can be swept to its exact expiry cycle. With the shorter 16-clock window, the sequences through the grace window and the reset pulse can be checked clock by clock. The 8-clock interval is shorter than the window, which makes repeated timeouts inside one window reachable.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int REG_W     = 7;
  localparam int F_RUN     = 0;
  localparam int F_IEN     = 1;
  localparam int F_REN     = 2;
  localparam int F_SEL_LO  = 3;
  localparam int F_FLAG    = 5;
  localparam int F_RESTART = 6;

  typedef enum logic [1:0] {
    GR_IDLE  = 2'd0,
    GR_WAIT  = 2'd1,
    GR_PULSE = 2'd2
  } grace_state_t;

  // Last count value before expiry for a given interval select.
  function automatic logic [31:0] wrap_value(input int unsigned base,
                                             input int unsigned step,
                                             input logic [1:0] sel);
    return (32'd1 << (base + step * 32'(sel))) - 32'd1;
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             timeout_evt,
  output logic             run,
  output logic             irq_en,
  output logic             rst_en,
  output logic [1:0]       sel,
  output logic             flag,
  output logic             restart,
  output logic [REG_W-1:0] rd_data
);
  logic flag_clr;

  assign restart  = wr_en && wr_data[F_RESTART];
  assign flag_clr = wr_en && (wr_data[F_FLAG] || wr_data[F_RESTART]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      irq_en <= 1'b0;
      rst_en <= 1'b0;
      sel    <= 2'd0;
    end else if (wr_en) begin
      run    <= wr_data[F_RUN];
      irq_en <= wr_data[F_IEN];
      rst_en <= wr_data[F_REN];
      sel    <= wr_data[F_SEL_LO +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag <= 1'b0;
    else if (timeout_evt) flag <= 1'b1;
    else if (flag_clr)    flag <= 1'b0;
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[F_RUN]          = run;
    rd_data[F_IEN]          = irq_en;
    rd_data[F_REN]          = rst_en;
    rd_data[F_SEL_LO +: 2]  = sel;
    rd_data[F_FLAG]         = flag;
  end

  // R4: flag survives any cycle with no clear or restart write
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int TMO_BASE = 10,
  parameter int TMO_STEP = 2,
  localparam int CNT_W   = TMO_BASE + 3 * TMO_STEP
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       timeout_evt
);
  logic [CNT_W-1:0] cnt;
  logic [31:0]      last;
  logic             at_last;

  assign last        = wrap_value(TMO_BASE, TMO_STEP, sel);
  assign at_last     = (32'(cnt) == last);
  assign timeout_evt = run && !restart && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= '0;
    else if (timeout_evt) cnt <= '0;
    else if (run)         cnt <= cnt + CNT_W'(1);
  end

  // R2: a stopped counter keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !restart |=> $stable(cnt));
  // R3: restart returns the count to zero
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
endmodule

// File: rtl/wdg_grace.sv
module wdg_grace
  import wdg_pkg::*;
#(
  parameter int GRACE_CLKS = 512,
  parameter int PULSE_CLKS = 4,
  localparam int GW = $clog2(GRACE_CLKS + 1),
  localparam int PW = $clog2(PULSE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_evt,
  input  logic rst_en,
  input  logic restart,
  output logic rst_out
);
  grace_state_t   state;
  logic [GW-1:0]  gcnt;
  logic [PW-1:0]  pcnt;
  logic           g_last;
  logic           p_last;

  assign g_last  = (gcnt == GW'(GRACE_CLKS - 1));
  assign p_last  = (pcnt == PW'(PULSE_CLKS - 1));
  assign rst_out = (state == GR_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GR_IDLE;
      gcnt  <= '0;
      pcnt  <= '0;
    end else begin
      unique case (state)
        GR_IDLE: if (timeout_evt && rst_en) begin
          state <= GR_WAIT;
          gcnt  <= '0;
        end
        GR_WAIT: begin
          if (restart) begin
            state <= GR_IDLE;
          end else if (g_last) begin
            state <= GR_PULSE;
            pcnt  <= '0;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        GR_PULSE: begin
          if (p_last) state <= GR_IDLE;
          else        pcnt  <= pcnt + PW'(1);
        end
        default: state <= GR_IDLE;
      endcase
    end
  end

  // R6: the pulse starts only at the end of a full window
  a_r6_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> ($past(state) == GR_WAIT) && ($past(gcnt) == GW'(GRACE_CLKS - 1)));
  // R6: the pulse is not cut short
  a_r6_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out && !p_last |=> rst_out);
  // R7: restart inside the window disarms it
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GR_WAIT) && restart |=> (state == GR_IDLE));
  // R8: without reset enable a timeout arms nothing
  a_r8_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GR_IDLE) && timeout_evt && !rst_en |=> (state == GR_IDLE));
  // R9: a second timeout does not rewind the window
  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GR_WAIT) && timeout_evt && !g_last |=> gcnt == $past(gcnt) + GW'(1));
endmodule

// File: rtl/watchdog_ctl.sv
module watchdog_ctl
  import wdg_pkg::*;
#(
  parameter int TMO_BASE   = 10,
  parameter int TMO_STEP   = 2,
  parameter int GRACE_CLKS = 512,
  parameter int PULSE_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic             sys_rst
);
  logic       run;
  logic       irq_en;
  logic       rst_en;
  logic [1:0] sel;
  logic       flag;
  logic       restart;
  logic       timeout_evt;

  wdg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .timeout_evt(timeout_evt), .run(run), .irq_en(irq_en), .rst_en(rst_en),
    .sel(sel), .flag(flag), .restart(restart), .rd_data(rd_data)
  );

  wdg_counter #(.TMO_BASE(TMO_BASE), .TMO_STEP(TMO_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .sel(sel),
    .timeout_evt(timeout_evt)
  );

  wdg_grace #(.GRACE_CLKS(GRACE_CLKS), .PULSE_CLKS(PULSE_CLKS)) u_grace (
    .clk(clk), .rst_n(rst_n), .timeout_evt(timeout_evt), .rst_en(rst_en),
    .restart(restart), .rst_out(sys_rst)
  );

  assign irq = flag && irq_en;

  // R7: a restart leaves no interrupt pending on the next cycle
  a_r7_restart_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !irq);
  // R2: the interrupt appears only after a timeout event
  a_r2_irq_from_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(timeout_evt));
endmodule

// File: tb/test_watchdog_ctl.sv
`timescale 1ns/1ps
module test_watchdog_ctl;
  localparam int BASE = 3;
  localparam int STEP = 1;
  localparam int G    = 16;
  localparam int P    = 4;

  localparam logic [6:0] RUN = 7'h01, IEN = 7'h02, REN = 7'h04,
                         CLR = 7'h20, RST = 7'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic [6:0] rd_data;
  logic       irq;
  logic       sys_rst;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  watchdog_ctl #(.TMO_BASE(BASE), .TMO_STEP(STEP), .GRACE_CLKS(G), .PULSE_CLKS(P))
    i_watchdog_ctl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                    .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst));

  function automatic logic [6:0] selv(input int s);
    return 7'(s << 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hits;
    waitn(2);
    check("R1 rd_data in reset", rd_data, 0);
    check("R1 sys_rst in reset", sys_rst, 0);
    rst_n = 1'b1;
    waitn(2);
    check("R1 rd_data after reset", rd_data, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 sys_rst after reset", sys_rst, 0);

    // R2 sweep over every interval select
    for (int s = 0; s < 4; s++) begin
      int len;
      len = 1 << (BASE + STEP * s);
      wr(RST | CLR | RUN | selv(s));
      check("R3 restart reads 0", rd_data[6], 0);
      waitn(len - 1);
      check("R2 flag before interval", rd_data[5], 0);
      waitn(1);
      check("R2 flag at interval", rd_data[5], 1);
      check("R5 irq masked", irq, 0);
      wr(RST | CLR);
    end

    // R2 counter holds while run is clear
    wr(RST | CLR | RUN);
    waitn(3);
    wr(7'h00);
    waitn(40);
    check("R2 no timeout while stopped", rd_data[5], 0);
    wr(RUN);
    waitn(3);
    check("R2 resumed count before expiry", rd_data[5], 0);
    waitn(1);
    check("R2 resumed count expiry", rd_data[5], 1);
    wr(RST | CLR);

    // R3 write with restart bit clear keeps the count
    wr(RST | CLR | RUN | selv(1));
    waitn(2);
    wr(RUN | selv(1));
    waitn(12);
    check("R3 write-0 no restart, before", rd_data[5], 0);
    waitn(1);
    check("R3 write-0 no restart, at", rd_data[5], 1);
    // R3 restart mid-count starts a full interval again
    wr(RST | CLR | RUN | selv(1));
    waitn(10);
    wr(RST | RUN | selv(1));
    waitn(15);
    check("R3 restart extends, before", rd_data[5], 0);
    waitn(1);
    check("R3 restart extends, at", rd_data[5], 1);

    // R4 sticky flag, write-one-to-clear
    wr(selv(1));
    check("R4 write without clear keeps flag", rd_data, 32'h28);
    waitn(5);
    check("R4 flag still set", rd_data[5], 1);
    wr(CLR | selv(1));
    check("R4 clear write", rd_data, 32'h08);

    // R5 interrupt follows flag and enable
    wr(RST | CLR | RUN);
    waitn(8);
    check("R5 flag set, enable off", irq, 0);
    wr(RUN | IEN);
    check("R5 irq with enable", irq, 1);
    wr(IEN);
    check("R5 irq held while stopped", irq, 1);
    wr(CLR | IEN);
    check("R5 irq cleared with flag", irq, 0);
    wr(RST | CLR);

    // R6 delayed reset pulse
    wr(RST | CLR | RUN | REN | selv(3));
    waitn(64);
    check("R6 flag at timeout", rd_data[5], 1);
    check("R6 no immediate reset", sys_rst, 0);
    waitn(G - 1);
    check("R6 reset low before window end", sys_rst, 0);
    waitn(1);
    check("R6 reset rises after window", sys_rst, 1);
    for (int k = 1; k < P; k++) begin
      waitn(1);
      check("R6 reset held", sys_rst, 1);
    end
    waitn(1);
    check("R6 reset pulse ends", sys_rst, 0);
    wr(RST | CLR);

    // R7 restart inside window cancels
    wr(RST | CLR | RUN | REN | selv(3));
    waitn(64);
    check("R7 flag at timeout", rd_data[5], 1);
    waitn(7);
    wr(RST | RUN | REN | selv(3));
    check("R7 flag cleared by restart", rd_data[5], 0);
    hits = 0;
    for (int k = 0; k < 30; k++) begin
      waitn(1);
      if (sys_rst) hits++;
    end
    check("R7 reset cancelled", hits, 0);
    wr(RST | CLR);

    // R8 no reset without reset enable
    wr(RST | CLR | RUN | selv(3));
    waitn(64);
    check("R8 flag at timeout", rd_data[5], 1);
    hits = 0;
    for (int k = 0; k < 30; k++) begin
      waitn(1);
      if (sys_rst) hits++;
    end
    check("R8 reset never asserted", hits, 0);
    wr(RST | CLR);

    // R9 repeated timeouts in window do not move the pulse
    wr(RST | CLR | RUN | REN);
    waitn(8);
    check("R9 first timeout", rd_data[5], 1);
    waitn(G - 1);
    check("R9 reset low before window end", sys_rst, 0);
    waitn(1);
    check("R9 reset rises on schedule", sys_rst, 1);
    waitn(P - 1);
    check("R9 reset still high", sys_rst, 1);
    waitn(1);
    check("R9 pulse length kept", sys_rst, 0);
    wr(RST | CLR);
    waitn(30);
    check("R9 idle after cleanup", sys_rst, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule